// File: doc/BRIEF.md
# Closed-caption line inserter

This block places a caption waveform on one chosen line of one chosen field of a video timing stream. A host loads two 7-bit characters and the block marks them as ready. When the video timing reaches the programmed field, line and start pixel, the block emits a serial frame on a one-bit override level with a valid strobe. The luma path uses the strobe to replace its sample with that level. The frame has a clock run-in, a start pattern, and then both characters, each with an odd parity bit.

Video timing enters as a line count, a pixel count, a field identifier and a pixel strobe. Every bit lasts a fixed number of pixel strobes, set by a parameter. If no characters are ready when the chosen line arrives, the block still sends a frame, carrying two null characters. After a frame that carried host characters, the block drops the ready flag so that the host can load the next pair.

Top module: `cc_line_inserter`

## Requirements
- R1: After reset, `cc_valid`, `cc_level` and `data_ready` are all low.
- R2: A `host_wr` pulse while `data_ready` is low stores both words and raises `data_ready` on that edge.
- R3: A `host_wr` pulse while `data_ready` is high is ignored, and the next frame carries the words stored earlier.
- R4: A frame starts on a clock edge where `pix_ce` is high, `cfg_en` is high, `field_id` equals `cfg_field`, `line_num` equals the zero-extended `cfg_line` and `pix_num` equals the zero-extended `cfg_hoff`. The first bit appears on that edge. No other line, field or pixel starts a frame.
- R5: A frame has 33 bits sent in this order: 14 run-in bits alternating 1,0 and starting with 1; the start bits 0, 0, 1; `word1` least significant bit first; its odd parity bit; `word2` least significant bit first; its odd parity bit.
- R6: Each bit is held for `PIX_PER_BIT` pixel strobes, and `cc_level` changes only on edges where `pix_ce` is high. `cc_valid` stays high for exactly 33 × `PIX_PER_BIT` strobes. This holds whatever the spacing of `pix_ce`.
- R7: If `data_ready` is low when a frame starts, the frame carries two null characters: seven zero bits followed by a parity bit of 1.
- R8: `data_ready` stays high until a frame that carried the host words ends. It falls on the same edge that `cc_valid` falls.
- R9: `cc_level` is low whenever `cc_valid` is low.
- R10: While `cfg_en` is low, no frame starts and `data_ready` is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Insertion enable |
| cfg_field | input | 1 | Field that carries the frame |
| cfg_hoff | input | 10 | Start pixel of the frame |
| cfg_line | input | 6 | Line that carries the frame |
| host_wr | input | 1 | Load strobe for the two words |
| host_word1 | input | 7 | First character |
| host_word2 | input | 7 | Second character |
| data_ready | output | 1 | Stored words are waiting to be sent |
| line_num | input | LINE_W | Current line count |
| pix_num | input | PIX_W | Current pixel count |
| field_id | input | 1 | Current field |
| pix_ce | input | 1 | Pixel strobe; counts advance on it |
| cc_level | output | 1 | Override level for the luma path |
| cc_valid | output | 1 | Override in force |

## Verification
The cases that are hardest to reach from the ports involve the ready flag. One is a write that lands while earlier words are still waiting. The other is a selected line that arrives with nothing loaded. In both cases the effect shows only as frame content one field or more later. The bench generates full fields of timing and loads or re-writes the words at chosen points before the target line. It scores every emitted pixel against a queue of expected line, pixel and level triples. A final pass spaces the pixel strobe to every other clock to show that the bit length depends on strobes, not clocks.

// File: rtl/cc_line_inserter.sv
module cc_line_inserter #(
  parameter int LINE_W      = 11,
  parameter int PIX_W       = 13,
  parameter int PIX_PER_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_field,
  input  logic [9:0]        cfg_hoff,
  input  logic [5:0]        cfg_line,
  input  logic              host_wr,
  input  logic [6:0]        host_word1,
  input  logic [6:0]        host_word2,
  output logic              data_ready,
  input  logic [LINE_W-1:0] line_num,
  input  logic [PIX_W-1:0]  pix_num,
  input  logic              field_id,
  input  logic              pix_ce,
  output logic              cc_level,
  output logic              cc_valid
);
  localparam int NBITS = 33;
  localparam int IDX_W = 6;
  localparam int SUB_W = (PIX_PER_BIT > 1) ? $clog2(PIX_PER_BIT) : 1;
  localparam logic [13:0] RUNIN = 14'b01_0101_0101_0101;

  logic [6:0]       w1, w2;
  logic             rdy, busy, took;
  logic [NBITS-1:0] shreg;
  logic [IDX_W-1:0] idx;
  logic [SUB_W-1:0] sub;

  logic [6:0]       c1, c2;
  logic [NBITS-1:0] frame_d;
  logic             hit, last_sub, last_bit;

  assign c1 = rdy ? w1 : 7'd0;
  assign c2 = rdy ? w2 : 7'd0;
  assign frame_d = {~^c2, c2, ~^c1, c1, 3'b100, RUNIN};

  assign hit = cfg_en && (field_id == cfg_field)
            && (line_num == LINE_W'(cfg_line))
            && (pix_num == PIX_W'(cfg_hoff));
  assign last_sub = (sub == SUB_W'(PIX_PER_BIT - 1));
  assign last_bit = (idx == IDX_W'(NBITS - 1));

  assign data_ready = rdy;
  assign cc_valid   = busy;
  assign cc_level   = busy & shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w1    <= '0;
      w2    <= '0;
      rdy   <= 1'b0;
      busy  <= 1'b0;
      took  <= 1'b0;
      shreg <= '0;
      idx   <= '0;
      sub   <= '0;
    end else begin
      if (host_wr && !rdy) begin
        w1  <= host_word1;
        w2  <= host_word2;
        rdy <= 1'b1;
      end
      if (pix_ce) begin
        if (!busy) begin
          if (hit) begin
            busy  <= 1'b1;
            shreg <= frame_d;
            took  <= rdy;
            idx   <= '0;
            sub   <= '0;
          end
        end else if (last_sub) begin
          sub <= '0;
          if (last_bit) begin
            busy  <= 1'b0;
            shreg <= '0;
            if (took) rdy <= 1'b0;
          end else begin
            idx   <= idx + 1'b1;
            shreg <= shreg >> 1;
          end
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end

  logic [15:0] chk_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) chk_cnt <= '0;
    else if (cc_valid && pix_ce) chk_cnt <= chk_cnt + 1'b1;
    else if (!cc_valid) chk_cnt <= '0;
  end

  p_frame_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cc_valid) |-> (chk_cnt == 16'(NBITS * PIX_PER_BIT)));

  p_level_on_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cc_level) |-> $past(pix_ce));

  p_start_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cc_valid) |-> $past(cfg_en && pix_ce && (field_id == cfg_field)
                              && (line_num == LINE_W'(cfg_line))
                              && (pix_num == PIX_W'(cfg_hoff))));

  p_ready_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_ready) |-> $fell(cc_valid));

  p_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && $past(data_ready)) |-> ($stable(w1) && $stable(w2)));

  p_quiet_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_valid |-> !cc_level);
endmodule

// File: tb/cc_line_inserter_test.sv
`timescale 1ns/1ps
module cc_line_inserter_test;
  localparam int LINE_W = 11;
  localparam int PIX_W  = 13;
  localparam int PPB    = 4;
  localparam int HTOT   = 300;
  localparam int NLINE  = 24;
  localparam int WDOG   = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0, cfg_field = 1'b0;
  logic [9:0] cfg_hoff = 10'd0;
  logic [5:0] cfg_line = 6'd0;
  logic host_wr = 1'b0;
  logic [6:0] host_word1 = 7'd0, host_word2 = 7'd0;
  logic data_ready;
  logic [LINE_W-1:0] ln = '0;
  logic [PIX_W-1:0] px = '0;
  logic fld = 1'b0;
  logic pix_ce = 1'b1;
  logic half = 1'b0;
  logic cc_level, cc_valid;

  int checks = 0;
  int fails = 0;
  logic [LINE_W+PIX_W:0] expq[$];

  always #2 clk = ~clk;

  cc_line_inserter #(.LINE_W(LINE_W), .PIX_W(PIX_W), .PIX_PER_BIT(PPB)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_field(cfg_field),
    .cfg_hoff(cfg_hoff), .cfg_line(cfg_line), .host_wr(host_wr),
    .host_word1(host_word1), .host_word2(host_word2), .data_ready(data_ready),
    .line_num(ln), .pix_num(px), .field_id(fld), .pix_ce(pix_ce),
    .cc_level(cc_level), .cc_valid(cc_valid));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor first, then advance the video timing
  always @(negedge clk) begin
    if (rst_n) begin
      if (pix_ce && cc_valid) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R4 unexpected output", {ln, px}, 0);
        end else begin
          logic [LINE_W+PIX_W:0] e;
          e = expq.pop_front();
          chk(e == {ln, px, cc_level}, "R5 pixel", {ln, px, cc_level}, e);
        end
      end
      if (!cc_valid && cc_level) chk(1'b0, "R9 level", 1, 0);
    end
    if (pix_ce) begin
      if (px == PIX_W'(HTOT - 1)) begin
        px = '0;
        if (ln == LINE_W'(NLINE - 1)) begin
          ln = '0;
          fld = ~fld;
        end else ln = ln + 1'b1;
      end else px = px + 1'b1;
    end
    pix_ce = half ? ~pix_ce : 1'b1;
  end

  task automatic push_line(input int line, input int hoff, input logic [6:0] a, input logic [6:0] b);
    for (int k = 0; k < 33; k++) begin
      logic v;
      if (k < 14) v = (k % 2 == 0);
      else if (k < 16) v = 1'b0;
      else if (k == 16) v = 1'b1;
      else if (k < 24) v = a[k-17];
      else if (k == 24) v = ~^a;
      else if (k < 32) v = b[k-25];
      else v = ~^b;
      for (int j = 0; j < PPB; j++)
        expq.push_back({LINE_W'(line), PIX_W'(hoff + k*PPB + j), v});
    end
  endtask

  task automatic wait_pos(input logic f, input int l, input int p);
    do @(posedge clk); while (!(fld == f && ln == LINE_W'(l) && px == PIX_W'(p)));
  endtask

  task automatic host_write(input logic [6:0] a, input logic [6:0] b);
    @(negedge clk);
    host_word1 = a; host_word2 = b; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!cc_valid && !cc_level && !data_ready, "R1 reset", {cc_valid, cc_level, data_ready}, 0);
    rst_n = 1'b1;
    cfg_en = 1'b1; cfg_field = 1'b0; cfg_line = 6'd21; cfg_hoff = 10'd135;

    // host data on field 0, line 21
    host_write(7'h41, 7'h7A);
    chk(data_ready, "R2 ready set", data_ready, 1);
    push_line(21, 135, 7'h41, 7'h7A);
    wait_pos(1'b1, 0, 0);
    chk(expq.size() == 0, "R5 frame consumed", expq.size(), 0);
    chk(!data_ready, "R8 ready cleared", data_ready, 0);

    // nothing loaded: nulls
    push_line(21, 135, 7'h00, 7'h00);
    wait_pos(1'b0, 0, 0);
    wait_pos(1'b1, 0, 0);
    chk(expq.size() == 0, "R7 null frame consumed", expq.size(), 0);
    chk(!data_ready, "R7 ready stays low", data_ready, 0);

    // other field/line/offset; second write ignored
    @(negedge clk);
    cfg_field = 1'b1; cfg_line = 6'd5; cfg_hoff = 10'd40;
    host_write(7'h55, 7'h2A);
    host_write(7'h7F, 7'h7F);
    chk(data_ready, "R2 ready after write", data_ready, 1);
    push_line(5, 40, 7'h55, 7'h2A);
    wait_pos(1'b1, 4, 0);
    chk(data_ready, "R8 ready held before line", data_ready, 1);
    wait_pos(1'b1, 10, 0);
    chk(expq.size() == 0, "R3 frame with first words", expq.size(), 0);
    chk(!data_ready, "R8 ready cleared after frame", data_ready, 0);

    // disabled: no frame, ready untouched
    wait_pos(1'b0, 0, 0);
    @(negedge clk);
    cfg_en = 1'b0;
    host_write(7'h13, 7'h64);
    wait_pos(1'b1, 0, 0);
    wait_pos(1'b0, 0, 0);
    chk(data_ready, "R10 ready unchanged", data_ready, 1);
    chk(expq.size() == 0, "R10 no frame", expq.size(), 0);

    // re-enable with a strobe every other clock
    @(negedge clk);
    cfg_en = 1'b1; half = 1'b1;
    push_line(5, 40, 7'h13, 7'h64);
    wait_pos(1'b1, 10, 0);
    chk(expq.size() == 0, "R6 spaced strobe frame", expq.size(), 0);
    chk(!data_ready, "R6 ready cleared", data_ready, 0);
    finish_run();
  end
endmodule